// File: doc/BRIEF.md
# Digital Potentiometer Register and Nonvolatile Controller

This block keeps the register state behind a digitally set resistor ladder: a volatile wiper position, an 8-bit nonvolatile start-up position and a small control register. A byte-level serial front end, outside this block, presents decoded register writes, register reads and the end-of-transaction (STOP) event. The wiper position and the shutdown-control level come out as plain outputs that drive the ladder.

Register index 0 reaches two registers. A mode bit in the control register picks which one. With the mode bit clear, a write goes to the nonvolatile start-up register and is also copied into the wiper. The nonvolatile part is modelled as a register plus a cycle-count timer. It takes its staged value only after STOP and stays busy for a set number of cycles. While it is busy, the volatile registers refuse writes. A recall request stands in for power-up. It forces the wiper to its mid-scale default, restores the control defaults and, after a set delay, copies the stored start-up value into the wiper and raises `ready`.

Top module: `pot_reg_ctrl`

## Requirements
- R1: After reset, `wiper` equals RESET_WIPER (40h by default), `ready` is 0, `nv_busy` is 0 and `run_en` is 1.
- R2: A `recall_req` pulse sampled at edge k loads the low WIPER_W bits of the stored start-up value into `wiper` and raises `ready` at edge k+RECALL_CYCLES.
- R3: With the mode bit (control bit 7) set to 1, a write to index 0 changes only `wiper` (low WIPER_W bits of `wdata`). A read of index 0 returns the wiper, zero-extended. The stored start-up value is not changed, and a later STOP starts no timed write.
- R4: With the mode bit at 0, a write to index 0 loads `wiper` on the next edge and stages all 8 bits for the nonvolatile register. `nv_busy` rises only on the edge after a STOP with a staged value. A read of index 0 returns the stored 8-bit value.
- R5: `nv_busy` stays high for exactly NV_CYCLES cycles. The stored value changes when it falls, and reads of index 0 return the old value until then.
- R6: While `nv_busy` is 1, writes to index 0 (in either mode) and to index 2 are ignored, and further STOPs do not extend the timed write.
- R7: Index 2 reads as {mode bit 7, shutdown-control bit 6, busy bit 5, bits 4..0 zero}. Writes set bits 7 and 6 only. Bit 6 drives `run_en` (0 requests shutdown).
- R8: Writes to any index other than 0 and 2 are accepted and discarded, and reads of those indexes return 00h.
- R9: While `ready` is 0, writes have no effect and reads return 00h.
- R10: A STOP with nothing staged starts no timed write. When several writes precede one STOP, the last value written is the one stored.
- R11: A recall request sets `wiper` to RESET_WIPER, `ready` to 0 and the mode and shutdown-control bits to 0 and 1 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| recall_req | input | 1 | Power-up recall trigger pulse |
| wr_en | input | 1 | Register write strobe from the byte front end |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register index |
| wdata | input | DATA_W | Write data |
| bus_stop | input | 1 | STOP seen at the end of a transaction |
| rdata | output | DATA_W | Read data, valid the cycle after `rd_en` |
| wiper | output | WIPER_W | Current tap position |
| run_en | output | 1 | Shutdown-control level (1 = normal operation) |
| nv_busy | output | 1 | Timed nonvolatile write in progress |
| ready | output | 1 | Recall finished; register access allowed |

## Verification
A table of writes and reads works through both settings of the mode bit. It shows the difference between a wiper-only write and a write that stages a start-up value, and it shows that the control register keeps only its two writable bits. Directed sequences then issue STOP with and without a staged value and try writes during the busy window. They sample `nv_busy` one cycle before and one cycle after its expected end, which catches an off-by-one in the timer. A recall during normal operation checks the mid-scale default and that no access gets through before `ready`. The recalled wiper value then shows that only the low wiper bits of an 8-bit stored value are used.

// File: rtl/pot_pkg.sv
package pot_pkg;
   // register indexes decoded by the front end
   localparam int REG_POS = 0;
   localparam int REG_CTL = 2;
   // control register bit positions
   localparam int CTL_MODE = 7;
   localparam int CTL_RUN  = 6;
   localparam int CTL_BUSY = 5;
endpackage

// File: rtl/pot_nv_cell.sv
module pot_nv_cell #(
   parameter int DATA_W    = 8,
   parameter int NV_CYCLES = 4_000_000,
   parameter logic [DATA_W-1:0] NV_INIT = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stage_we,
   input  logic [DATA_W-1:0] stage_data,
   input  logic              commit,
   output logic              busy,
   output logic [DATA_W-1:0] nv_q
);
   localparam int CNT_W = $clog2(NV_CYCLES + 1);

   logic [DATA_W-1:0] stage_q;
   logic              pend_q;
   logic [CNT_W-1:0]  cnt_q;

   if (NV_CYCLES < 1) begin : g_bad_cycles
      $error("pot_nv_cell: NV_CYCLES must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         pend_q  <= 1'b0;
         busy    <= 1'b0;
         cnt_q   <= '0;
         nv_q    <= NV_INIT;
      end else if (busy) begin
         if (cnt_q == '0) begin
            nv_q <= stage_q;
            busy <= 1'b0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end else if (commit && pend_q) begin
         busy   <= 1'b1;
         pend_q <= 1'b0;
         cnt_q  <= CNT_W'(NV_CYCLES - 1);
      end else if (stage_we) begin
         stage_q <= stage_data;
         pend_q  <= 1'b1;
      end
   end
endmodule

// File: rtl/pot_recall_seq.sv
module pot_recall_seq #(
   parameter int RECALL_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic load,
   output logic ready
);
   localparam int CNT_W = $clog2(RECALL_CYCLES + 1);

   logic             active_q;
   logic [CNT_W-1:0] cnt_q;

   if (RECALL_CYCLES < 1) begin : g_bad_recall
      $error("pot_recall_seq: RECALL_CYCLES must be at least 1");
   end

   assign load = active_q && (cnt_q == '0) && !req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         ready    <= 1'b0;
      end else if (req) begin
         active_q <= 1'b1;
         ready    <= 1'b0;
         cnt_q    <= CNT_W'(RECALL_CYCLES - 1);
      end else if (active_q) begin
         if (cnt_q == '0) begin
            active_q <= 1'b0;
            ready    <= 1'b1;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end
endmodule

// File: rtl/pot_read_mux.sv
module pot_read_mux
   import pot_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 8,
   parameter int WIPER_W  = 7,
   parameter int READ_LAT = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic               ready,
   input  logic               mode_vol,
   input  logic               run,
   input  logic               busy,
   input  logic [WIPER_W-1:0] wiper,
   input  logic [DATA_W-1:0]  nv_q,
   output logic [DATA_W-1:0]  rdata
);
   logic [DATA_W-1:0] sel_val;
   logic [DATA_W-1:0] ctl_val;

   always_comb begin
      ctl_val           = '0;
      ctl_val[CTL_MODE] = mode_vol;
      ctl_val[CTL_RUN]  = run;
      ctl_val[CTL_BUSY] = busy;
      sel_val           = '0;
      if (ready) begin
         if (addr == ADDR_W'(REG_POS))
            sel_val = mode_vol ? DATA_W'(wiper) : nv_q;
         else if (addr == ADDR_W'(REG_CTL))
            sel_val = ctl_val;
      end
   end

   if (READ_LAT == 0) begin : g_comb
      assign rdata = rd_en ? sel_val : '0;
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
   end else if (READ_LAT == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rdata <= '0;
         else if (rd_en)
            rdata <= sel_val;
      end
   end else begin : g_bad_lat
      $error("pot_read_mux: READ_LAT must be 0 or 1");
   end
endmodule

// File: rtl/pot_reg_ctrl.sv
module pot_reg_ctrl
   import pot_pkg::*;
#(
   parameter int ADDR_W        = 8,
   parameter int DATA_W        = 8,
   parameter int WIPER_W       = 7,
   parameter int RESET_WIPER   = 64,
   parameter logic [DATA_W-1:0] NV_INIT = 8'h40,
   parameter int NV_CYCLES     = 4_000_000,
   parameter int RECALL_CYCLES = 16,
   parameter int READ_LAT      = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               recall_req,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic               bus_stop,
   output logic [DATA_W-1:0]  rdata,
   output logic [WIPER_W-1:0] wiper,
   output logic               run_en,
   output logic               nv_busy,
   output logic               ready
);
   localparam logic [WIPER_W-1:0] WIPER_DEF = WIPER_W'(RESET_WIPER);

   if (DATA_W < 8) begin : g_bad_data
      $error("pot_reg_ctrl: DATA_W must hold the 8-bit control register");
   end
   if (WIPER_W > DATA_W) begin : g_bad_wiper
      $error("pot_reg_ctrl: WIPER_W must not exceed DATA_W");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("pot_reg_ctrl: ADDR_W must reach index 2");
   end

   logic              mode_vol;
   logic              acc_ok;
   logic              pos_we;
   logic              ctl_we;
   logic              load;
   logic [DATA_W-1:0] nv_q;

   assign acc_ok = wr_en && ready && !nv_busy;
   assign pos_we = acc_ok && (addr == ADDR_W'(REG_POS));
   assign ctl_we = acc_ok && (addr == ADDR_W'(REG_CTL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wiper    <= WIPER_DEF;
         mode_vol <= 1'b0;
         run_en   <= 1'b1;
      end else if (recall_req) begin
         wiper    <= WIPER_DEF;
         mode_vol <= 1'b0;
         run_en   <= 1'b1;
      end else if (load) begin
         wiper <= nv_q[WIPER_W-1:0];
      end else begin
         if (pos_we)
            wiper <= wdata[WIPER_W-1:0];
         if (ctl_we) begin
            mode_vol <= wdata[CTL_MODE];
            run_en   <= wdata[CTL_RUN];
         end
      end
   end

   pot_nv_cell #(
      .DATA_W    (DATA_W),
      .NV_CYCLES (NV_CYCLES),
      .NV_INIT   (NV_INIT)
   ) u_nv (
      .clk        (clk),
      .rst_n      (rst_n),
      .stage_we   (pos_we && !mode_vol && !recall_req),
      .stage_data (wdata),
      .commit     (bus_stop),
      .busy       (nv_busy),
      .nv_q       (nv_q)
   );

   pot_recall_seq #(
      .RECALL_CYCLES (RECALL_CYCLES)
   ) u_recall (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (recall_req),
      .load  (load),
      .ready (ready)
   );

   pot_read_mux #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .WIPER_W  (WIPER_W),
      .READ_LAT (READ_LAT)
   ) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .addr     (addr),
      .ready    (ready),
      .mode_vol (mode_vol),
      .run      (run_en),
      .busy     (nv_busy),
      .wiper    (wiper),
      .nv_q     (nv_q),
      .rdata    (rdata)
   );
endmodule

// File: rtl/pot_reg_chk.sv
module pot_reg_chk #(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter int WIPER_W     = 7,
   parameter int RESET_WIPER = 64,
   parameter int NV_CYCLES   = 4_000_000,
   parameter int READ_LAT    = 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               recall_req,
   input logic               wr_en,
   input logic               rd_en,
   input logic [ADDR_W-1:0]  addr,
   input logic               bus_stop,
   input logic [DATA_W-1:0]  rdata,
   input logic [WIPER_W-1:0] wiper,
   input logic               run_en,
   input logic               nv_busy,
   input logic               ready,
   input logic               mode_vol
);
   int unsigned busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         busy_len <= 0;
      else if (nv_busy)
         busy_len <= busy_len + 1;
      else
         busy_len <= 0;
   end

   // R5
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nv_busy) |-> busy_len == NV_CYCLES);

   // R4
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nv_busy) |-> $past(bus_stop));

   // R6
   busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nv_busy && wr_en && ready && !recall_req)
      |=> ($stable(wiper) && $stable(run_en) && $stable(mode_vol)));

   // R9
   not_ready_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> (run_en && !mode_vol));

   // R8
   reserved_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (READ_LAT == 1 && rd_en && addr != ADDR_W'(0) && addr != ADDR_W'(2))
      |=> rdata == '0);

   // R11
   recall_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      recall_req |=> (wiper == WIPER_W'(RESET_WIPER) && !ready));
endmodule

bind pot_reg_ctrl pot_reg_chk #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .WIPER_W     (WIPER_W),
   .RESET_WIPER (RESET_WIPER),
   .NV_CYCLES   (NV_CYCLES),
   .READ_LAT    (READ_LAT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .recall_req (recall_req),
   .wr_en      (wr_en),
   .rd_en      (rd_en),
   .addr       (addr),
   .bus_stop   (bus_stop),
   .rdata      (rdata),
   .wiper      (wiper),
   .run_en     (run_en),
   .nv_busy    (nv_busy),
   .ready      (ready),
   .mode_vol   (mode_vol)
);

// File: tb/pot_reg_ctrl_bench.sv
`timescale 1ns/1ps
module pot_reg_ctrl_bench;
   localparam int NVC = 40;
   localparam int RCC = 4;
   localparam int NV_ROWS = 25;
   localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_WP = 2'd2, OP_RUN = 2'd3;

   // {op, addr, data, expected}
   localparam logic [25:0] VEC [NV_ROWS] = '{
      {OP_RD,  8'h02, 8'h00, 8'h40},  // R7 control default
      {OP_RD,  8'h00, 8'h00, 8'h25},  // R4 mode 0 reads stored value
      {OP_WP,  8'h00, 8'h00, 8'h25},  // R2 recalled wiper
      {OP_WR,  8'h02, 8'hC0, 8'h00},
      {OP_RD,  8'h02, 8'h00, 8'hC0},  // R7
      {OP_WR,  8'h00, 8'h13, 8'h00},
      {OP_WP,  8'h00, 8'h00, 8'h13},  // R3
      {OP_RD,  8'h00, 8'h00, 8'h13},  // R3 mode 1 reads wiper
      {OP_WR,  8'h00, 8'hFF, 8'h00},
      {OP_RD,  8'h00, 8'h00, 8'h7F},  // R3 wiper width
      {OP_WP,  8'h00, 8'h00, 8'h7F},  // R3
      {OP_WR,  8'h02, 8'hFF, 8'h00},
      {OP_RD,  8'h02, 8'h00, 8'hC0},  // R7 busy and low bits not writable
      {OP_WR,  8'h02, 8'h00, 8'h00},
      {OP_RUN, 8'h00, 8'h00, 8'h00},  // R7 shutdown request
      {OP_RD,  8'h02, 8'h00, 8'h00},  // R7
      {OP_RD,  8'h00, 8'h00, 8'h25},  // R3 stored value untouched
      {OP_WR,  8'h01, 8'h5A, 8'h00},
      {OP_RD,  8'h01, 8'h00, 8'h00},  // R8
      {OP_RD,  8'h03, 8'h00, 8'h00},  // R8
      {OP_WP,  8'h00, 8'h00, 8'h7F},  // R8 wiper untouched
      {OP_WR,  8'h02, 8'h40, 8'h00},
      {OP_RD,  8'h02, 8'h00, 8'h40},  // R7
      {OP_RUN, 8'h00, 8'h00, 8'h01},  // R7
      {OP_WP,  8'h00, 8'h00, 8'h7F}   // R3
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       recall_req = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] addr = '0;
   logic [7:0] wdata = '0;
   logic       bus_stop = 1'b0;
   logic [7:0] rdata;
   logic [6:0] wiper;
   logic       run_en;
   logic       nv_busy;
   logic       ready;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   pot_reg_ctrl #(
      .NV_INIT       (8'h25),
      .NV_CYCLES     (NVC),
      .RECALL_CYCLES (RCC)
   ) u_pot_reg_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .recall_req (recall_req),
      .wr_en      (wr_en),
      .rd_en      (rd_en),
      .addr       (addr),
      .wdata      (wdata),
      .bus_stop   (bus_stop),
      .rdata      (rdata),
      .wiper      (wiper),
      .run_en     (run_en),
      .nv_busy    (nv_busy),
      .ready      (ready)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic do_stop();
      @(negedge clk);
      bus_stop = 1'b1;
      @(negedge clk);
      bus_stop = 1'b0;
   endtask

   task automatic do_recall();
      @(negedge clk);
      recall_req = 1'b1;
      @(negedge clk);
      recall_req = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 00 expected 01");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] rv;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 wiper", {1'b0, wiper}, 8'h40);
      chk("R1 ready", {7'b0, ready}, 8'h00);
      chk("R1 busy", {7'b0, nv_busy}, 8'h00);
      chk("R1 run_en", {7'b0, run_en}, 8'h01);
      // R9 access before ready
      do_wr(8'h00, 8'h11);
      do_wr(8'h02, 8'h80);
      chk("R9 wiper", {1'b0, wiper}, 8'h40);
      chk("R9 run_en", {7'b0, run_en}, 8'h01);
      do_rd(8'h02, rv);
      chk("R9 read", rv, 8'h00);
      // R2 recall
      do_recall();
      repeat (RCC + 2) @(negedge clk);
      chk("R2 ready", {7'b0, ready}, 8'h01);

      for (int i = 0; i < NV_ROWS; i++) begin
         logic [1:0] op;
         logic [7:0] va, vd, ve;
         {op, va, vd, ve} = VEC[i];
         case (op)
            OP_WR:  do_wr(va, vd);
            OP_RD:  begin do_rd(va, rv); chk($sformatf("table row %0d read", i), rv, ve); end
            OP_WP:  chk($sformatf("table row %0d wiper", i), {1'b0, wiper}, ve);
            default: chk($sformatf("table row %0d run_en", i), {7'b0, run_en}, ve);
         endcase
      end
      chk("R10 no stop no busy", {7'b0, nv_busy}, 8'h00);

      // R4 / R5 / R6 timed write
      do_wr(8'h00, 8'h5C);
      chk("R4 wiper", {1'b0, wiper}, 8'h5C);
      chk("R4 idle before stop", {7'b0, nv_busy}, 8'h00);
      do_rd(8'h00, rv);
      chk("R4 old stored", rv, 8'h25);
      do_stop();
      chk("R4 busy after stop", {7'b0, nv_busy}, 8'h01);
      do_rd(8'h02, rv);
      chk("R7 busy bit", rv, 8'h60);
      do_wr(8'h02, 8'hC0);
      do_rd(8'h02, rv);
      chk("R6 ctl locked", rv, 8'h60);
      do_wr(8'h00, 8'h11);
      chk("R6 wiper locked", {1'b0, wiper}, 8'h5C);
      do_stop();
      do_rd(8'h00, rv);
      chk("R5 old during busy", rv, 8'h25);
      repeat (NVC) @(negedge clk);
      chk("R5 busy ended", {7'b0, nv_busy}, 8'h00);
      do_rd(8'h00, rv);
      chk("R4 committed", rv, 8'h5C);

      // R10 stop without staging, then last of several wins
      do_stop();
      chk("R10 bare stop", {7'b0, nv_busy}, 8'h00);
      do_wr(8'h00, 8'h31);
      do_wr(8'h00, 8'hB2);
      chk("R4 low bits", {1'b0, wiper}, 8'h32);
      do_stop();
      repeat (NVC - 2) @(negedge clk);
      chk("R5 busy at end-1", {7'b0, nv_busy}, 8'h01);
      repeat (2) @(negedge clk);
      chk("R5 busy cleared", {7'b0, nv_busy}, 8'h00);
      do_rd(8'h00, rv);
      chk("R10 last value", rv, 8'hB2);

      // R11 / R2 recall during operation
      do_wr(8'h02, 8'h80);
      do_wr(8'h00, 8'h07);
      chk("R7 run_en low", {7'b0, run_en}, 8'h00);
      do_recall();
      chk("R11 wiper", {1'b0, wiper}, 8'h40);
      chk("R11 ready", {7'b0, ready}, 8'h00);
      chk("R11 run_en", {7'b0, run_en}, 8'h01);
      do_rd(8'h02, rv);
      chk("R9 read during recall", rv, 8'h00);
      do_wr(8'h00, 8'h11);
      repeat (RCC + 2) @(negedge clk);
      chk("R2 ready again", {7'b0, ready}, 8'h01);
      chk("R2 recalled wiper", {1'b0, wiper}, 8'h32);
      do_rd(8'h02, rv);
      chk("R11 mode reset", rv, 8'h40);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule